// File: doc/BRIEF.md
# Framed PCM Serial Transmitter with Robbed-Bit Signaling

This block puts one encoded voice word per frame onto a serial PCM line that several channels share. A frame strobe marks that a new word is ready. An external shift clock, with no fixed timing relation to the strobe, moves the bits onto the line. The block samples both the strobe and the shift clock in its own system clock domain through synchronizers and acts on their rising edges. The first shift-clock edge after a strobe loads the word. The bits then go out most significant first, one per shift-clock period. A bus enable is high only while this channel owns the line.

A frame counter runs over a twelve-frame cycle. In the default in-band mode, frame 6 of each cycle carries the A signaling input in place of the word's least significant bit, and frame 12 carries the B input. A polarity control can invert the inserted bit. In common-channel mode the word is never altered. The signaling bit that would have been inserted goes to a separate pin instead, where it is held until the next signaling frame replaces it.

Top module: `pcm_sig_tx`

## Requirements
- R1: During and after reset, and before any strobe, `pcm_oe` is 0, `pcm_data` is 0 and `sig_out` is 0. The frame counter restarts, so the first word loaded after reset belongs to frame 1.
- R2: The first rising edge of `shift_clk` after a rising edge of `frame_strobe` loads `pcm_word`. Bit 7 is driven after that edge, and each later rising shift edge moves one bit down, so bit 7 goes out first and bit 0 goes out last.
- R3: `pcm_oe` stays high for exactly 8 shift-clock periods from the loading edge. The 9th rising edge releases the line. Further shift edges before the next strobe leave `pcm_oe` at 0.
- R4: Frames are numbered 1 to 12 and the count then repeats. In in-band mode (`common_chan`=0), bit 0 of the frame-6 word is replaced by `sig_a` XOR `sig_invert`.
- R5: In in-band mode, bit 0 of the frame-12 word is replaced by `sig_b` XOR `sig_invert`.
- R6: In every frame other than 6 and 12, and in every frame while `common_chan`=1, all 8 bits go out unaltered.
- R7: With `sig_invert`=1, the inserted bit is the complement of the selected signaling input.
- R8: When `common_chan`=1, each frame-6 or frame-12 load captures the signaling bit that in-band mode would have inserted. `sig_out` shows that bit until the next such load. When `common_chan`=0, `sig_out` is 0.
- R9: A shift-clock edge that has no strobe before it since the last load starts no transmission.
- R10: `pcm_data` is 0 whenever `pcm_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | Asynchronous frame marker; its rising edge arms a load |
| shift_clk | input | 1 | Asynchronous external bit clock; it acts on its rising edges |
| pcm_word | input | 8 | Encoded word for the next frame |
| sig_a | input | 1 | A signaling input |
| sig_b | input | 1 | B signaling input |
| sig_invert | input | 1 | 1 inverts the signaling bit |
| common_chan | input | 1 | 1 selects common-channel mode |
| pcm_data | output | 1 | Serial data; 0 when released |
| pcm_oe | output | 1 | Bus drive enable for the shared line |
| sig_out | output | 1 | Separate signaling pin used in common-channel mode |

## Verification
The assertions assume two things about the inputs. Each high and each low phase of `shift_clk` and `frame_strobe` lasts longer than the synchronizer depth plus one system clock, so that every edge is detected exactly once. `pcm_word` and the signaling controls must also stay steady from the strobe until the loading edge. The bench meets this by holding every phase for six system clocks and by changing inputs only on falling clock edges between frames. It sweeps 48 consecutive frames across in-band, inverted and common-channel settings, and it sends extra shift pulses with no strobe, both after reset and after each word.

// File: rtl/pcm_sig_tx_pkg.sv
package pcm_sig_tx_pkg;

    localparam int WORD_W      = 8;
    localparam int FRAME_CYCLE = 12;
    localparam int SIG_GAP     = 6;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_A    = 2'd1,
        SLOT_B    = 2'd2
    } slot_e;

    // Signaling slot of a frame, given the count of frames already loaded in the cycle
    function automatic slot_e slot_of(input int unsigned done, input int unsigned gap,
                                      input int unsigned cycle);
        if (done == gap - 1)
            return SLOT_A;
        else if (done == cycle - 1)
            return SLOT_B;
        else
            return SLOT_NONE;
    endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int STAGES = pcm_sig_tx_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            last  <= chain[STAGES-1];
        end
    end

    assign rise_o = chain[STAGES-1] & ~last;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
    import pcm_sig_tx_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int CYCLE = FRAME_CYCLE,
    parameter int GAP   = SIG_GAP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         sig_a_i,
    input  logic         sig_b_i,
    input  logic         invert_i,
    input  logic         common_i,
    output logic [W-1:0] word_o,
    output logic         sig_hold_o
);
    localparam int CNW = $clog2(CYCLE);

    logic [CNW-1:0] done_cnt;
    slot_e          slot;
    logic           sig_bit;

    always_comb begin
        slot    = slot_of(int'(done_cnt), GAP, CYCLE);
        sig_bit = ((slot == SLOT_A) ? sig_a_i : sig_b_i) ^ invert_i;
        if (!common_i && slot != SLOT_NONE)
            word_o = {word_i[W-1:1], sig_bit};
        else
            word_o = word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_cnt   <= '0;
            sig_hold_o <= 1'b0;
        end else if (load_i) begin
            done_cnt <= (done_cnt == CNW'(CYCLE - 1)) ? '0 : done_cnt + 1'b1;
            if (common_i && slot != SLOT_NONE)
                sig_hold_o <= sig_bit;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done_cnt < CNW'(CYCLE)); // R4
    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(done_cnt)); // R4
    AST_SIG_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(sig_hold_o)); // R8
endmodule

// File: rtl/pcm_shift_out.sv
module pcm_shift_out #(
    parameter int W = pcm_sig_tx_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         step_i,
    output logic         data_o,
    output logic         oe_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  shreg;
    logic [CW-1:0] idx;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (load_i) begin
            shreg  <= word_i;
            idx    <= '0;
            active <= 1'b1;
        end else if (active && step_i) begin
            if (idx == CW'(W - 1))
                active <= 1'b0;
            idx   <= idx + 1'b1;
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    assign data_o = active & shreg[W-1];
    assign oe_o   = active;

    AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(load_i)); // R2
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> ($stable(shreg) && $stable(active))); // R3
    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(idx) == CW'(W - 1))); // R3
endmodule

// File: rtl/pcm_sig_tx.sv
module pcm_sig_tx
    import pcm_sig_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              shift_clk,
    input  logic [WORD_W-1:0] pcm_word,
    input  logic              sig_a,
    input  logic              sig_b,
    input  logic              sig_invert,
    input  logic              common_chan,
    output logic              pcm_data,
    output logic              pcm_oe,
    output logic              sig_out
);
    logic              strobe_rise;
    logic              shift_rise;
    logic              armed;
    logic              load;
    logic [WORD_W-1:0] tx_word;
    logic              sig_hold;

    pcm_edge_sync #(.STAGES(SYNC_DEPTH)) u_strobe_sync (
        .clk(clk), .rst(rst), .async_i(frame_strobe), .rise_o(strobe_rise));

    pcm_edge_sync #(.STAGES(SYNC_DEPTH)) u_shift_sync (
        .clk(clk), .rst(rst), .async_i(shift_clk), .rise_o(shift_rise));

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= strobe_rise | (armed & ~load);
    end

    assign load = shift_rise & armed;

    pcm_frame_seq #(.W(WORD_W), .CYCLE(FRAME_CYCLE), .GAP(SIG_GAP)) u_seq (
        .clk(clk), .rst(rst), .load_i(load), .word_i(pcm_word),
        .sig_a_i(sig_a), .sig_b_i(sig_b), .invert_i(sig_invert),
        .common_i(common_chan), .word_o(tx_word), .sig_hold_o(sig_hold));

    pcm_shift_out #(.W(WORD_W)) u_ser (
        .clk(clk), .rst(rst), .load_i(load), .word_i(tx_word),
        .step_i(shift_rise), .data_o(pcm_data), .oe_o(pcm_oe));

    assign sig_out = common_chan & sig_hold;

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pcm_oe |-> !pcm_data); // R10
    AST_NO_LOAD_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (shift_rise && !armed) |=> !$rose(pcm_oe)); // R9
endmodule

// File: tb/pcm_sig_tx_bench.sv
`timescale 1ns/1ps
module pcm_sig_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_strobe = 1'b0;
    logic       shift_clk = 1'b0;
    logic [7:0] pcm_word = 8'h00;
    logic       sig_a = 1'b0;
    logic       sig_b = 1'b0;
    logic       sig_invert = 1'b0;
    logic       common_chan = 1'b0;
    logic       pcm_data;
    logic       pcm_oe;
    logic       sig_out;

    int checks = 0;
    int errors = 0;
    int frames_sent = 0;
    logic held_sig = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pcm_sig_tx u_pcm_sig_tx (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .shift_clk(shift_clk),
        .pcm_word(pcm_word), .sig_a(sig_a), .sig_b(sig_b), .sig_invert(sig_invert),
        .common_chan(common_chan), .pcm_data(pcm_data), .pcm_oe(pcm_oe),
        .sig_out(sig_out));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (frame %0d)", req, actual,
                     expected, frames_sent);
        end
    endtask

    task automatic shift_pulse();
        shift_clk = 1'b1; tick(6);
        shift_clk = 1'b0; tick(6);
    endtask

    task automatic send_frame(input logic [7:0] w, input logic a, input logic b,
                              input logic inv, input logic cc);
        int unsigned fnum;
        logic [7:0] exp_w;
        logic sbit;
        pcm_word = w; sig_a = a; sig_b = b; sig_invert = inv; common_chan = cc;
        fnum = (frames_sent % 12) + 1;
        exp_w = w;
        sbit = ((fnum == 6) ? a : b) ^ inv;
        if ((fnum == 6 || fnum == 12) && !cc) exp_w[0] = sbit;   // R4 R5 R7
        if ((fnum == 6 || fnum == 12) && cc) held_sig = sbit;    // R8
        frame_strobe = 1'b1; tick(6);
        frame_strobe = 1'b0; tick(6);
        for (int k = 7; k >= 0; k--) begin
            shift_pulse();
            check("R3 enable", pcm_oe, 1'b1);
            if (fnum == 6)       check("R4 frame6 bit", pcm_data, exp_w[k]);
            else if (fnum == 12) check("R5 frame12 bit", pcm_data, exp_w[k]);
            else                 check("R2 R6 bit", pcm_data, exp_w[k]);
        end
        frames_sent++;
        for (int k = 0; k < 2; k++) begin
            shift_pulse();
            check("R3 released", pcm_oe, 1'b0);
            check("R10 quiet", pcm_data, 1'b0);
        end
        check("R8 sig_out", sig_out, cc ? held_sig : 1'b0);
    endtask

    initial begin
        tick(4);
        check("R1 oe", pcm_oe, 1'b0);
        check("R1 data", pcm_data, 1'b0);
        check("R1 sig", sig_out, 1'b0);
        rst = 1'b0;
        tick(4);
        check("R1 oe after", pcm_oe, 1'b0);
        // R9: shift edges without any strobe
        for (int k = 0; k < 3; k++) begin
            shift_clk = 1'b1; tick(6);
            check("R9 no start", pcm_oe, 1'b0);
            shift_clk = 1'b0; tick(6);
            check("R9 no start", pcm_oe, 1'b0);
        end
        // in-band, non-inverted, varied words and signaling values
        for (int f = 0; f < 24; f++)
            send_frame(8'((f * 37 + 5) % 256), f[0], ~f[1], 1'b0, 1'b0);
        // in-band, inverted (R7)
        for (int f = 0; f < 12; f++)
            send_frame(8'((f * 91 + 200) % 256), f[1], f[0], 1'b1, 1'b0);
        // common-channel mode (R8, R6)
        for (int f = 0; f < 12; f++)
            send_frame(8'((f * 53 + 17) % 256), 1'b1, f[0], f[2], 1'b1);
        common_chan = 1'b0;
        tick(2);
        check("R8 sig_out in-band", sig_out, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule